// File: doc/BRIEF.md
# Saturating and Rounding Signed Multiplier

This block multiplies two small two's-complement operands and presents the product in two reduced widths at once. One output clamps the exact product into a narrow signed range, so a result that does not fit pins to the nearest end of that range and never wraps. The other output keeps only the high-order part of the product. It rounds half up, by adding half of its least significant weight before dropping the low bits, and a clamp stage keeps that result from wrapping.

The product comes from a shift-and-add array in which the row for the top multiplier bit is subtracted, because that bit has a negative weight. Both reduced results pass through one output register stage. A consumer that needs a coarse level estimate reads the rounded output. A consumer that needs as much of the value as fits reads the clamped output.

Top module: `sat_round_mul`

## Requirements
- R1: An active-low reset clears both outputs to zero as soon as it is asserted, without waiting for a clock edge, and keeps them at zero while it is held.
- R2: Each output shows the result for the operands sampled at the most recent rising clock edge. Between edges it holds its value whatever the operands do.
- R3: When the exact product lies in [-32, 31], the 6-bit clamped output equals the product in two's complement.
- R4: When the exact product exceeds 31, including +64 from (-8)×(-8), the clamped output is +31 (6'h1F).
- R5: When the exact product is below -32, the clamped output is -32 (6'h20).
- R6: The 4-bit rounded output equals floor((product + 8) / 16) in two's complement, so product bit 4 carries the weight of the output LSB.
- R7: The rounded output never wraps. Its sign bit (bit 3) is set exactly when product + 8 is negative, and any value outside [-8, 7] would clamp to the nearer end. With the default widths the result lies in [-3, +4].
- R8: A product exactly halfway between two output steps rounds toward plus infinity. For example, +8 gives 1, -8 gives 0 and -24 gives -1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 4 | Multiplicand, two's complement |
| op_b | input | 4 | Multiplier, two's complement |
| sat_q | output | 6 | Registered clamped product |
| rnd_q | output | 4 | Registered rounded product |

## Verification
The bench builds the block with its default widths: 4-bit operands, a 6-bit clamped output and a 4-bit rounded output. At these widths all 256 operand pairs can be walked exhaustively against a reference built from the plain multiply and compare operators. The walk therefore reaches the lone +64 product, both clamp directions and every halfway rounding case. The rounded result's own clamp never has to act at these widths, so the no-wrap rule is checked through the sign of the rounded result across the full operand space.

// File: rtl/smr_pkg.sv
`timescale 1ns/1ps
package smr_pkg;
  // Decision taken by a clamp stage for one value
  typedef enum logic [1:0] {
    CL_PASS = 2'd0,
    CL_HIGH = 2'd1,
    CL_LOW  = 2'd2
  } clamp_e;
endpackage

// File: rtl/smr_prod.sv
`timescale 1ns/1ps
// Signed array multiplier: sign-extended multiplicand rows, top row subtracted.
module smr_prod #(
  parameter int IN_W = 4
) (
  input  logic [IN_W-1:0]   a,
  input  logic [IN_W-1:0]   b,
  output logic [2*IN_W-1:0] p
);
  localparam int PROD_W = 2 * IN_W;

  logic [PROD_W-1:0] a_ext;
  logic [PROD_W-1:0] row [IN_W];
  logic [PROD_W-1:0] acc [IN_W+1];

  assign a_ext  = {{IN_W{a[IN_W-1]}}, a};
  assign acc[0] = '0;

  for (genvar i = 0; i < IN_W; i++) begin : g_row
    assign row[i] = b[i] ? (a_ext << i) : '0;
    if (i == IN_W - 1) begin : g_neg
      assign acc[i+1] = acc[i] - row[i];
    end else begin : g_pos
      assign acc[i+1] = acc[i] + row[i];
    end
  end

  assign p = acc[IN_W];
endmodule

// File: rtl/smr_clamp.sv
`timescale 1ns/1ps
// Narrows a signed value; out-of-range inputs pin to the nearest limit.
module smr_clamp
  import smr_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 6
) (
  input  logic [IN_W-1:0]  d,
  output logic [OUT_W-1:0] q
);
  localparam int TOP_W = IN_W - OUT_W + 1;

  logic [TOP_W-1:0] top_bits;
  logic             top_ones;
  logic             top_zeros;
  clamp_e           sel;

  assign top_bits  = d[IN_W-1:OUT_W-1];
  assign top_ones  = &top_bits;
  assign top_zeros = ~|top_bits;

  always_comb begin
    if (top_ones || top_zeros) begin
      sel = CL_PASS;
    end else if (d[IN_W-1]) begin
      sel = CL_LOW;
    end else begin
      sel = CL_HIGH;
    end
  end

  always_comb begin
    unique case (sel)
      CL_HIGH: q = {1'b0, {(OUT_W-1){1'b1}}};
      CL_LOW:  q = {1'b1, {(OUT_W-1){1'b0}}};
      default: q = d[OUT_W-1:0];
    endcase
  end
endmodule

// File: rtl/smr_round.sv
`timescale 1ns/1ps
// Round half up to the top RND_W bits, then guard against wrap.
module smr_round #(
  parameter int PROD_W = 8,
  parameter int RND_W  = 4
) (
  input  logic [PROD_W-1:0] p,
  output logic [RND_W-1:0]  r
);
  localparam int SHIFT = PROD_W - RND_W;
  localparam logic [PROD_W:0] HALF = (PROD_W+1)'(1) << (SHIFT - 1);

  logic [PROD_W:0]  sum;
  logic [RND_W:0]   wide;
  logic             unused_frac;

  assign sum         = {p[PROD_W-1], p} + HALF;
  assign wide        = sum[PROD_W:SHIFT];
  assign unused_frac = ^sum[SHIFT-1:0];

  smr_clamp #(
    .IN_W  (RND_W + 1),
    .OUT_W (RND_W)
  ) u_guard (
    .d (wide),
    .q (r)
  );
endmodule

// File: rtl/sat_round_mul.sv
`timescale 1ns/1ps
module sat_round_mul #(
  parameter int IN_W  = 4,
  parameter int SAT_W = 6,
  parameter int RND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  op_a,
  input  logic [IN_W-1:0]  op_b,
  output logic [SAT_W-1:0] sat_q,
  output logic [RND_W-1:0] rnd_q
);
  localparam int PROD_W = 2 * IN_W;

  logic [PROD_W-1:0] prod;
  logic [SAT_W-1:0]  sat_d;
  logic [RND_W-1:0]  rnd_d;

  smr_prod #(.IN_W(IN_W)) u_prod (
    .a (op_a),
    .b (op_b),
    .p (prod)
  );

  smr_clamp #(.IN_W(PROD_W), .OUT_W(SAT_W)) u_sat (
    .d (prod),
    .q (sat_d)
  );

  smr_round #(.PROD_W(PROD_W), .RND_W(RND_W)) u_rnd (
    .p (prod),
    .r (rnd_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_q <= '0;
      rnd_q <= '0;
    end else begin
      sat_q <= sat_d;
      rnd_q <= rnd_d;
    end
  end
endmodule

// File: rtl/sat_round_mul_chk.sv
`timescale 1ns/1ps
module sat_round_mul_chk #(
  parameter int IN_W  = 4,
  parameter int SAT_W = 6,
  parameter int RND_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IN_W-1:0]  op_a,
  input logic [IN_W-1:0]  op_b,
  input logic [SAT_W-1:0] sat_q,
  input logic [RND_W-1:0] rnd_q
);
  localparam int SHIFT = 2 * IN_W - RND_W;
  localparam int HALF  = 1 << (SHIFT - 1);
  localparam int SMAX  = (1 << (SAT_W - 1)) - 1;
  localparam int SMIN  = -(1 << (SAT_W - 1));
  localparam int RMAX  = (1 << (RND_W - 1)) - 1;
  localparam int RMIN  = -(1 << (RND_W - 1));

  logic live;
  int   ref_p;
  int   ref_raw;
  int   ref_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= 1'b0;
      ref_p <= 0;
    end else begin
      live  <= 1'b1;
      ref_p <= int'($signed(op_a)) * int'($signed(op_b));
    end
  end

  always_comb begin
    ref_raw = (ref_p + HALF) >>> SHIFT;
    if (ref_raw > RMAX)      ref_r = RMAX;
    else if (ref_raw < RMIN) ref_r = RMIN;
    else                     ref_r = ref_raw;
  end

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sat_q == '0 && rnd_q == '0));
  // R3, R2
  a_r3_sat_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ref_p <= SMAX && ref_p >= SMIN) |-> int'($signed(sat_q)) == ref_p);
  // R4
  a_r4_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ref_p > SMAX) |-> int'($signed(sat_q)) == SMAX);
  // R5
  a_r5_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ref_p < SMIN) |-> int'($signed(sat_q)) == SMIN);
  // R6, R8
  a_r6_round: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> int'($signed(rnd_q)) == ref_r);
  // R7
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> rnd_q[RND_W-1] == ((ref_p + HALF) < 0));
endmodule

bind sat_round_mul sat_round_mul_chk #(
  .IN_W  (IN_W),
  .SAT_W (SAT_W),
  .RND_W (RND_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .op_a  (op_a),
  .op_b  (op_b),
  .sat_q (sat_q),
  .rnd_q (rnd_q)
);

// File: tb/sat_round_mul_tb.sv
`timescale 1ns/1ps
module sat_round_mul_tb;
  typedef struct packed {
    logic signed [3:0] a;
    logic signed [3:0] b;
    logic signed [5:0] s;
    logic signed [3:0] r;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{ 4'sd3,   4'sd2,   6'sd6,   4'sd0 },
    '{ 4'sd7,   4'sd7,   6'sd31,  4'sd3 },
    '{-4'sd8,  -4'sd8,   6'sd31,  4'sd4 },
    '{-4'sd8,   4'sd7,  -6'sd32, -4'sd3 },
    '{ 4'sd2,   4'sd4,   6'sd8,   4'sd1 },
    '{-4'sd2,   4'sd4,  -6'sd8,   4'sd0 },
    '{ 4'sd4,   4'sd6,   6'sd24,  4'sd2 },
    '{-4'sd4,   4'sd6,  -6'sd24, -4'sd1 },
    '{ 4'sd0,  -4'sd8,   6'sd0,   4'sd0 },
    '{ 4'sd4,  -4'sd8,  -6'sd32, -4'sd2 },
    '{-4'sd4,  -4'sd8,   6'sd31,  4'sd2 },
    '{ 4'sd5,  -4'sd7,  -6'sd32, -4'sd2 },
    '{-4'sd1,  -4'sd1,   6'sd1,   4'sd0 },
    '{ 4'sd7,  -4'sd8,  -6'sd32, -4'sd3 },
    '{ 4'sd6,   4'sd5,   6'sd30,  4'sd2 }
  };

  logic       clk;
  logic       rst_n;
  logic [3:0] op_a;
  logic [3:0] op_b;
  logic [5:0] sat_q;
  logic [3:0] rnd_q;
  int n_chk;
  int n_err;
  bit done;

  sat_round_mul u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .op_a  (op_a),
    .op_b  (op_b),
    .sat_q (sat_q),
    .rnd_q (rnd_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_sat(input int p);
    if (p > 31)  return 31;
    if (p < -32) return -32;
    return p;
  endfunction

  function automatic int ref_rnd(input int p);
    int t;
    t = (p + 8) >>> 4;
    if (t > 7)  return 7;
    if (t < -8) return -8;
    return t;
  endfunction

  function automatic string sat_req(input int p);
    if (p > 31)  return "R4 clamp high";
    if (p < -32) return "R5 clamp low";
    return "R3 pass";
  endfunction

  task automatic apply(input int a, input int b);
    @(negedge clk);
    op_a = 4'(a);
    op_b = 4'(b);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    op_a  = 4'd7;
    op_b  = 4'd7;
    repeat (3) @(negedge clk);
    check("R1 reset sat", int'($signed(sat_q)), 0);
    check("R1 reset rnd", int'($signed(rnd_q)), 0);
    rst_n = 1'b1;

    // table of directed vectors
    for (int i = 0; i < NV; i++) begin
      int p;
      apply(int'(VEC[i].a), int'(VEC[i].b));
      p = int'(VEC[i].a) * int'(VEC[i].b);
      check(sat_req(p), int'($signed(sat_q)), int'(VEC[i].s));
      if (((p + 8) & 15) == 0) check("R8 tie", int'($signed(rnd_q)), int'(VEC[i].r));
      else                     check("R6 round", int'($signed(rnd_q)), int'(VEC[i].r));
    end

    // R2: output holds until the rising edge, then follows
    apply(7, 7);
    @(negedge clk);
    op_a = 4'd3;
    op_b = 4'd3;
    #1;
    check("R2 hold sat", int'($signed(sat_q)), 31);
    check("R2 hold rnd", int'($signed(rnd_q)), 3);
    @(negedge clk);
    check("R2 update sat", int'($signed(sat_q)), 9);
    check("R2 update rnd", int'($signed(rnd_q)), 1);

    // exhaustive walk against the reference operators
    for (int a = -8; a < 8; a++) begin
      for (int b = -8; b < 8; b++) begin
        int p;
        int r;
        apply(a, b);
        p = a * b;
        r = int'($signed(rnd_q));
        check(sat_req(p), int'($signed(sat_q)), ref_sat(p));
        check("R6 round", r, ref_rnd(p));
        check("R7 no wrap", int'(rnd_q[3]), int'((p + 8) < 0));
      end
    end

    // R1: asynchronous clear between edges
    apply(7, 7);
    #1;
    rst_n = 1'b0;
    #1;
    check("R1 async sat", int'($signed(sat_q)), 0);
    check("R1 async rnd", int'($signed(rnd_q)), 0);
    @(negedge clk);
    check("R1 held sat", int'($signed(sat_q)), 0);
    rst_n = 1'b1;
    apply(-8, -8);
    check("R4 plus 64", int'($signed(sat_q)), 31);
    check("R7 plus 64", int'($signed(rnd_q)), 4);

    done = 1'b1;
    finish_run();
  end
endmodule